// File: doc/BRIEF.md
# Character LCD Bus Controller

This block drives a two-line, 16-column character display module that has an 8-bit parallel bus. The bus consists of a register-select line, a read/write line, an enable strobe and a bidirectional data byte. The byte is split into an output, an output-enable and an input, and the pad ring joins them. Before every write, the controller reads the display's instruction register and keeps polling it until the busy flag in bit 7 reads clear. Only then does it drive the byte and strobe the enable line.

After reset the block issues the start-up commands on its own, with the host handshake held off. The sequence is function set 0x38 (8-bit bus, two lines, 5x7 font), then 0x0E (display and cursor on, no blink), then 0x06 (address increments). After that, the host presents one request at a time on a valid/ready handshake. A request writes a raw command byte, writes a character, or moves the cursor to a line and column. Setup time and enable width are parameters counted in clock cycles. A busy poll that never clears within a configurable number of reads raises a sticky error flag, and the pending write then goes out anyway.

Top module: `lcd_char_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `req_ready`, `lcd_en`, `lcd_data_oe` and `busy_err` are all 0.
- R2: After reset the block writes the commands 0x38, 0x0E and 0x06, in that order, with `lcd_rs`=0. `req_ready` stays 0 until the last of the three completes.
- R3: Op 2'b00 writes `req_data` unchanged as a command, with `lcd_rs`=0 and `lcd_rw`=0. Clear (0x01) and home (0x02) are sent this way.
- R4: Op 2'b01 writes `req_data` as a character, with `lcd_rs`=1 and `lcd_rw`=0.
- R5: Op 2'b10 or 2'b11 sets the cursor. The line is `req_data[4]` and the column is `req_data[3:0]`. The command written is 0x80 | line<<6 | column, and `req_data[7:5]` has no effect.
- R6: Every write is preceded by one or more reads with `lcd_rs`=0 and `lcd_rw`=1. The reads repeat while `lcd_data_i[7]` is 1 at the end of the enable pulse. Only bit 7 is examined.
- R7: `lcd_data_oe` is 0 whenever `lcd_rw` is 1. It is 1 during every write enable pulse.
- R8: Each enable pulse is high for exactly EN_CYC cycles. For at least SETUP_CYC cycles before the pulse rises, `lcd_rs` and `lcd_rw` are held stable with enable low, and they stay stable while enable is high.
- R9: When BUSY_LIMIT consecutive polls all read busy, `busy_err` sets and stays set until reset, and the write proceeds after the last poll.
- R10: `req_ready` is 1 only when no transfer is in progress. A request is taken when `req_valid` and `req_ready` are both 1, and `req_ready` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 00 command, 01 character, 1x cursor |
| req_data | input | 8 | Byte, or {line, column} for the cursor op |
| lcd_rs | output | 1 | Register select (0 instruction, 1 data) |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_en | output | 1 | Enable strobe |
| lcd_data_o | output | 8 | Data bus outgoing value |
| lcd_data_oe | output | 1 | Data bus output enable |
| lcd_data_i | input | 8 | Data bus incoming value |
| busy_err | output | 1 | Sticky busy-poll timeout flag |

## Verification
The bench places a display model on the bus that holds the busy flag for a chosen number of polls per transfer. The non-busy bits it returns are nonzero, so a controller that tests the whole byte instead of bit 7 would never leave the poll loop. A stall longer than the limit checks that the flag rises on exactly the last permitted poll and that the character still goes out. A controller that aborted the write, or cleared the flag, would break the write order or the sticky check. Cursor requests carry junk in the upper bits and target the last column of line 1, which catches a wrong line-bit position or missing masking. Enable width, setup hold and bus release are measured on every pulse, so a controller that drove the bus during a read, or changed the register select while enable was high, is reported when it happens.

// File: rtl/lcd_char_ctrl.sv
module lcd_char_ctrl #(
  parameter int SETUP_CYC  = 2,
  parameter int EN_CYC     = 4,
  parameter int BUSY_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic [7:0] req_data,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] lcd_data_o,
  output logic       lcd_data_oe,
  input  logic [7:0] lcd_data_i,
  output logic       busy_err
);
  localparam int CMAX = (SETUP_CYC > EN_CYC) ? SETUP_CYC : EN_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int TW   = $clog2(BUSY_LIMIT + 1);

  typedef enum logic [2:0] {S_PSET, S_PEN, S_WSET, S_WEN, S_IDLE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tries;
  logic [7:0]    job_byte;
  logic          job_rs;
  logic [1:0]    init_idx;
  logic          init_done;

  function automatic logic [7:0] boot_cmd(input logic [1:0] i);
    case (i)
      2'd0:    return 8'h38;
      2'd1:    return 8'h0E;
      default: return 8'h06;
    endcase
  endfunction

  wire writing   = (state == S_WSET) || (state == S_WEN);
  wire [7:0] cursor_cmd = {1'b1, req_data[4], 2'b00, req_data[3:0]};

  assign lcd_en      = (state == S_PEN) || (state == S_WEN);
  assign lcd_rw      = !writing;
  assign lcd_rs      = writing && job_rs;
  assign lcd_data_oe = writing;
  assign lcd_data_o  = job_byte;
  assign req_ready   = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_PSET;
      cnt       <= CW'(SETUP_CYC - 1);
      tries     <= '0;
      job_byte  <= 8'h38;
      job_rs    <= 1'b0;
      init_idx  <= 2'd0;
      init_done <= 1'b0;
      busy_err  <= 1'b0;
    end else begin
      case (state)
        S_PSET, S_WSET: begin
          if (cnt == '0) begin
            state <= (state == S_PSET) ? S_PEN : S_WEN;
            cnt   <= CW'(EN_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_PEN: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            cnt <= CW'(SETUP_CYC - 1);
            if (lcd_data_i[7] && tries != TW'(BUSY_LIMIT - 1)) begin
              tries <= tries + 1'b1;
              state <= S_PSET;
            end else begin
              if (lcd_data_i[7]) busy_err <= 1'b1;
              tries <= '0;
              state <= S_WSET;
            end
          end
        end
        S_WEN: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!init_done && init_idx != 2'd2) begin
            init_idx <= init_idx + 1'b1;
            job_byte <= boot_cmd(init_idx + 1'b1);
            cnt      <= CW'(SETUP_CYC - 1);
            state    <= S_PSET;
          end else begin
            init_done <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: begin
          if (req_valid) begin
            job_byte <= req_op[1] ? cursor_cmd : req_data;
            job_rs   <= (req_op == 2'b01);
            cnt      <= CW'(SETUP_CYC - 1);
            state    <= S_PSET;
          end
        end
      endcase
    end
  end

  a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw |-> !lcd_data_oe);
  a_r7_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && !lcd_rw) |-> lcd_data_oe);
  a_r8_hold_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_data_o)));
  a_r8_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> ($stable(lcd_rs) && $stable(lcd_rw)));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |=> busy_err);
  a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r2_no_ready_in_boot: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
endmodule

// File: tb/lcd_char_ctrl_test.sv
module lcd_char_ctrl_test;
  localparam int SETUP = 2, ENW = 3, LIMIT = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [7:0] req_data = 0;
  logic req_ready, lcd_rs, lcd_rw, lcd_en, lcd_data_oe, busy_err;
  logic [7:0] lcd_data_o, lcd_data_i;

  always #5 clk = ~clk;

  lcd_char_ctrl #(.SETUP_CYC(SETUP), .EN_CYC(ENW), .BUSY_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_en(lcd_en), .lcd_data_o(lcd_data_o), .lcd_data_oe(lcd_data_oe),
    .lcd_data_i(lcd_data_i), .busy_err(busy_err));

  int busy_left = 1;
  assign lcd_data_i = (lcd_rw && lcd_en) ? ((busy_left > 0) ? 8'hC5 : 8'h45) : 8'h00;

  int vectors = 0, fails = 0, cycles = 0;
  int exp_wr[$];
  int exp_polls[$];
  int s_op[$], s_data[$], s_busy[$];
  int boot_busy[$];
  bit model_err = 0;
  int en_run = 0, set_run = 0, polls = 0, writes = 0;
  logic p_en = 0, p_rs = 0, p_rw = 1, p_busy = 0;
  logic [7:0] p_data = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_req(input int op, input int d, input int b);
    s_op.push_back(op); s_data.push_back(d); s_busy.push_back(b);
  endtask

  initial begin
    exp_wr = '{9'h038, 9'h00E, 9'h006};
    exp_polls = '{2, 1, 3};
    boot_busy = '{0, 2};
    push_req(0, 8'h01, 0);
    push_req(1, 8'h41, 2);
    push_req(2, 8'h05, 1);
    push_req(3, 8'hFF, 0);
    push_req(0, 8'h02, 1);
    push_req(1, 8'h7A, 10);
    push_req(1, 8'h30, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!req_ready && !lcd_en && !lcd_data_oe && !busy_err, "R1 reset outputs",
          {req_ready, lcd_en, lcd_data_oe, busy_err}, 0);
    end
    rst_n = 1;
  end

  always @(negedge clk) if (rst_n) begin
    cycles++;
    if (lcd_en && !p_en) begin
      chk(set_run >= SETUP, "R8 setup before enable", set_run, SETUP);
      en_run = 1;
    end else if (lcd_en) en_run++;
    if (!lcd_en && p_en) begin
      chk(en_run == ENW, "R8 enable width", en_run, ENW);
      if (p_rw) begin
        chk(p_rs == 0, "R6 poll uses instruction register", p_rs, 0);
        polls++;
        if (p_busy) begin
          busy_left--;
          if (polls == LIMIT) model_err = 1;
        end
      end else begin
        int e, ep;
        e = exp_wr.size() ? exp_wr.pop_front() : -1;
        ep = exp_polls.size() ? exp_polls.pop_front() : -1;
        chk({p_rs, p_data} == e, "R2/R3/R4/R5 written byte", {p_rs, p_data}, e);
        chk(polls == ep, "R6/R9 poll count before write", polls, ep);
        polls = 0;
        writes++;
        if (writes < 3) busy_left = boot_busy[writes - 1];
      end
    end
    if (!lcd_en) begin
      if (p_en || lcd_rs != p_rs || lcd_rw != p_rw) set_run = 1; else set_run++;
    end else set_run = 0;
    chk(!(lcd_rw && lcd_data_oe), "R7 bus released on read", lcd_data_oe, 0);
    if (lcd_en && !lcd_rw) chk(lcd_data_oe, "R7 bus driven on write", lcd_data_oe, 1);
    chk(busy_err == model_err, "R9 busy error flag", busy_err, model_err);
    chk(req_ready == (exp_wr.size() == 0), "R10/R2 ready", req_ready, exp_wr.size() == 0);
    if (req_valid && !req_ready) req_valid = 0;
    else if (req_ready && !req_valid && s_op.size() > 0) begin
      int op, d, b, cmd;
      op = s_op.pop_front(); d = s_data.pop_front(); b = s_busy.pop_front();
      if (op >= 2) cmd = 8'h80 | ((d >> 4) & 1) << 6 | (d & 15);
      else cmd = d;
      if (op == 1) cmd = cmd | 9'h100;
      req_valid = 1; req_op = op[1:0]; req_data = d[7:0];
      exp_wr.push_back(cmd);
      exp_polls.push_back((b + 1 < LIMIT) ? b + 1 : LIMIT);
      busy_left = b;
    end
    p_en = lcd_en; p_rs = lcd_rs; p_rw = lcd_rw; p_data = lcd_data_o;
    p_busy = lcd_data_i[7];
    if (s_op.size() == 0 && exp_wr.size() == 0 && req_ready && !req_valid) begin
      chk(writes == 10, "R2/R3/R4/R5 total writes", writes, 10);
      chk(busy_err == 1, "R9 flag still set at end", busy_err, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
    if (cycles > 20000) begin
      chk(0, "watchdog", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule